// File: doc/BRIEF.md
# Interval Timer Counter Channel

This block is a single down-counting channel of a PC-style interval timer. It runs from the system clock and advances once for every cycle on which the timebase strobe `tb_tick` is high. The strobe stands for the fixed 1193180 Hz input rate. Software programs the channel in two steps. First it writes a packed 8-bit control word on a port shared by all channels. Then it loads the count one byte at a time through the channel's own data port.

The channel has two output behaviours. In one-shot mode the output goes high when the count expires and stays high. In square-wave mode the output toggles without end, and its period equals the loaded count. A gate input pauses counting. A status bit copies the output pin so that software can poll it. Counting is always binary. Control words that address another channel, or that ask for an access method or mode this channel does not support, are ignored.

Top module: `pit_channel`

## Requirements
- R1: During and after reset, `out_o` and `stat_o` are low, and data writes are ignored until a valid control word arrives.
- R2: The control word is decoded as follows: bits 7:6 are the channel number, bits 5:4 are the access method (01 = low byte only, 11 = low then high), bits 3:1 are the mode (000 = one-shot, 011 or 111 = square wave), and bit 0 is ignored. A word is ignored and changes no state if its channel number differs from `CHAN_ID`, if its access method is 00 or 10, or if its mode is anything else.
- R3: With access method 11, the first data write supplies bits 7:0 of the count and the second supplies bits 15:8. Counting starts only on the second write, and a lone first write starts nothing.
- R4: With access method 01, each data write loads the count at once, with the high byte taken as zero.
- R5: In one-shot mode, `out_o` is low from the cycle after a count load. It rises after N counted ticks and then stays high until the next control word or count load.
- R6: A valid control word stops counting and, from the next cycle, drives `out_o` low for one-shot mode or high for square-wave mode.
- R7: In square-wave mode with count N, `out_o` is high for ceil(N/2) counted ticks and then low for floor(N/2), and this repeats. A count of 1 gives one tick high and one tick low.
- R8: The count advances only on cycles where both `tb_tick` and `gate` are high. On other cycles without writes, `out_o` holds its value.
- R9: A loaded count of 0x0000 acts as 65536 ticks.
- R10: `stat_o` equals `out_o` on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_tick | input | 1 | Timebase strobe; one count tick per high cycle |
| gate | input | 1 | Counting enable; counting pauses while low |
| ctrl_we | input | 1 | Control word write strobe (shared port) |
| ctrl_byte | input | 8 | Control word value |
| data_we | input | 1 | Count byte write strobe for this channel |
| data_byte | input | 8 | Count byte value |
| out_o | output | 1 | Channel output pin |
| stat_o | output | 1 | Status bit copying the output |

## Verification
A byte pointer left in the wrong state moves the load to the wrong write. The first output edge after that write then lands many cycles early or late. Half-period lengths that are swapped or truncated show on the first falling edge of a square wave, within ceil(N/2) ticks of the load. A gate or strobe that is not honoured shifts the terminal-count edge by exactly the number of blocked cycles. A decode that accepts a foreign or unsupported control word shows one cycle after that write, as a one-shot output that has reached its terminal count falling low.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int CNT_LW = CNT_W + 1;

  typedef enum logic {OP_ONESHOT = 1'b0, OP_SQUARE = 1'b1} op_e;

  typedef struct packed {
    logic [1:0] chan;
    logic [1:0] acc;
    logic [2:0] mode;
    logic       bcd;
  } ctrl_word_t;

  localparam logic [1:0] ACC_LO_ONLY = 2'b01;
  localparam logic [1:0] ACC_LO_HI   = 2'b11;

  function automatic logic mode_supported(input logic [2:0] m);
    return (m == 3'b000) || (m[1:0] == 2'b11);
  endfunction
endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter logic [1:0] CHAN_ID = 2'd2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [7:0]        ctrl_byte,
  input  logic              data_we,
  input  logic [BYTE_W-1:0] data_byte,
  output logic              cfg_evt,
  output op_e               cfg_op,
  output op_e               op,
  output logic              load_evt,
  output logic [CNT_LW-1:0] load_val
);
  ctrl_word_t        cw;
  logic              acc_ok;
  logic              armed_q;
  logic              two_q;
  logic              msb_next_q;
  logic [BYTE_W-1:0] lsb_q;
  op_e               op_q;
  logic              wr_ok;
  logic [CNT_W-1:0]  raw;
  logic              unused_bcd;

  assign cw         = ctrl_word_t'(ctrl_byte);
  assign unused_bcd = cw.bcd;
  assign acc_ok     = (cw.acc == ACC_LO_ONLY) || (cw.acc == ACC_LO_HI);
  assign cfg_evt    = ctrl_we && (cw.chan == CHAN_ID) && acc_ok && mode_supported(cw.mode);
  assign cfg_op     = (cw.mode[1:0] == 2'b11) ? OP_SQUARE : OP_ONESHOT;
  assign op         = op_q;

  // control word has priority over a data write in the same cycle
  assign wr_ok    = data_we && !cfg_evt && armed_q;
  assign load_evt = wr_ok && (!two_q || msb_next_q);

  always_comb begin
    if (two_q) raw = {data_byte, lsb_q};
    else       raw = {{BYTE_W{1'b0}}, data_byte};
    if (raw == '0) load_val = {1'b1, {CNT_W{1'b0}}};
    else           load_val = {1'b0, raw};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q    <= 1'b0;
      two_q      <= 1'b0;
      msb_next_q <= 1'b0;
      lsb_q      <= '0;
      op_q       <= OP_ONESHOT;
    end else if (cfg_evt) begin
      armed_q    <= 1'b1;
      two_q      <= (cw.acc == ACC_LO_HI);
      msb_next_q <= 1'b0;
      op_q       <= cfg_op;
    end else if (wr_ok && two_q) begin
      if (!msb_next_q) begin
        lsb_q      <= data_byte;
        msb_next_q <= 1'b1;
      end else begin
        msb_next_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         at_one
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - W'(1);
  end

  assign at_one = (cnt_q == W'(1));
endmodule

// File: rtl/pit_wave.sv
module pit_wave
  import pit_pkg::*;
#(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_evt,
  input  op_e          cfg_op,
  input  op_e          op,
  input  logic         load_evt,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         at_one,
  output logic         out,
  output logic         ctr_load,
  output logic [W-1:0] ctr_val,
  output logic         ctr_dec
);
  logic         run_q;
  logic         out_q;
  logic [W-1:0] hi_q;
  logic [W-1:0] lo_q;
  logic [W-1:0] hi_new;
  logic [W-1:0] lo_half;
  logic [W-1:0] lo_new;

  assign hi_new  = (load_val + W'(1)) >> 1;
  assign lo_half = load_val >> 1;
  assign lo_new  = (lo_half == '0) ? W'(1) : lo_half;
  assign out     = out_q;

  always_comb begin
    ctr_load = 1'b0;
    ctr_val  = load_val;
    ctr_dec  = 1'b0;
    if (cfg_evt) begin
      ctr_load = 1'b0;
    end else if (load_evt) begin
      ctr_load = 1'b1;
      ctr_val  = (op == OP_SQUARE) ? hi_new : load_val;
    end else if (run_q && step) begin
      if (at_one && (op == OP_SQUARE)) begin
        ctr_load = 1'b1;
        ctr_val  = out_q ? lo_q : hi_q;
      end else begin
        ctr_dec = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      out_q <= 1'b0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else if (cfg_evt) begin
      run_q <= 1'b0;
      out_q <= (cfg_op == OP_SQUARE);
    end else if (load_evt) begin
      run_q <= 1'b1;
      out_q <= (op == OP_SQUARE);
      hi_q  <= hi_new;
      lo_q  <= lo_new;
    end else if (run_q && step && at_one) begin
      if (op == OP_SQUARE) begin
        out_q <= ~out_q;
      end else begin
        out_q <= 1'b1;
        run_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter logic [1:0] CHAN_ID = 2'd2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tb_tick,
  input  logic       gate,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_byte,
  input  logic       data_we,
  input  logic [7:0] data_byte,
  output logic       out_o,
  output logic       stat_o
);
  localparam int LW = CNT_LW;

  logic          cfg_evt;
  op_e           cfg_op;
  op_e           op_q;
  logic          load_evt;
  logic [LW-1:0] load_val;
  logic          step;
  logic          at_one;
  logic          ctr_load;
  logic [LW-1:0] ctr_val;
  logic          ctr_dec;
  logic          wave_out;

  assign step = tb_tick && gate;

  pit_ctrl #(.CHAN_ID(CHAN_ID)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ctrl_we  (ctrl_we),
    .ctrl_byte(ctrl_byte),
    .data_we  (data_we),
    .data_byte(data_byte),
    .cfg_evt  (cfg_evt),
    .cfg_op   (cfg_op),
    .op       (op_q),
    .load_evt (load_evt),
    .load_val (load_val)
  );

  pit_counter #(.W(LW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load    (ctr_load),
    .load_val(ctr_val),
    .dec     (ctr_dec),
    .at_one  (at_one)
  );

  pit_wave #(.W(LW)) u_wave (
    .clk     (clk),
    .rst     (rst),
    .cfg_evt (cfg_evt),
    .cfg_op  (cfg_op),
    .op      (op_q),
    .load_evt(load_evt),
    .load_val(load_val),
    .step    (step),
    .at_one  (at_one),
    .out     (wave_out),
    .ctr_load(ctr_load),
    .ctr_val (ctr_val),
    .ctr_dec (ctr_dec)
  );

  assign out_o  = wave_out;
  assign stat_o = wave_out;
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
  import pit_pkg::*;
#(
  parameter logic [1:0] CHAN_ID = 2'd2
) (
  input logic       clk,
  input logic       rst,
  input logic       ctrl_we,
  input logic [7:0] ctrl_byte,
  input logic       data_we,
  input logic       tb_tick,
  input logic       gate,
  input logic       out_o,
  input op_e        op,
  input logic       load_evt
);
  logic own, acc_ok, is_one, is_sq, unused_b0;

  assign unused_b0 = ctrl_byte[0];
  assign own    = ctrl_we && (ctrl_byte[7:6] == CHAN_ID);
  assign acc_ok = (ctrl_byte[5:4] == 2'b01) || (ctrl_byte[5:4] == 2'b11);
  assign is_one = (ctrl_byte[3:1] == 3'b000);
  assign is_sq  = (ctrl_byte[2:1] == 2'b11);

  AST_CFG_ONESHOT_LOW: assert property (@(posedge clk) disable iff (rst)
    own && acc_ok && is_one |=> !out_o); // R6
  AST_CFG_SQUARE_HIGH: assert property (@(posedge clk) disable iff (rst)
    own && acc_ok && is_sq |=> out_o); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctrl_we && !data_we && !(tb_tick && gate) |=> $stable(out_o)); // R8
  AST_TC_STICKY: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ONESHOT) && out_o && !ctrl_we && !data_we |=> out_o); // R5
  AST_LOAD_ONESHOT_LOW: assert property (@(posedge clk) disable iff (rst)
    load_evt && (op == OP_ONESHOT) |=> !out_o); // R5
  AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ctrl_we && (ctrl_byte[7:6] != CHAN_ID) && !data_we && out_o && (op == OP_ONESHOT) |=> out_o); // R2
endmodule

bind pit_channel pit_channel_chk #(.CHAN_ID(CHAN_ID)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ctrl_we  (ctrl_we),
  .ctrl_byte(ctrl_byte),
  .data_we  (data_we),
  .tb_tick  (tb_tick),
  .gate     (gate),
  .out_o    (out_o),
  .op       (op_q),
  .load_evt (load_evt)
);

// File: tb/sim_pit_channel.sv
module sim_pit_channel;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tb_tick = 1'b1;
  logic       gate = 1'b1;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_byte = '0;
  logic       data_we = 1'b0;
  logic [7:0] data_byte = '0;
  logic       out_o;
  logic       stat_o;

  always #2 clk = ~clk;

  pit_channel #(.CHAN_ID(2'd2)) u0 (
    .clk(clk), .rst(rst), .tb_tick(tb_tick), .gate(gate),
    .ctrl_we(ctrl_we), .ctrl_byte(ctrl_byte),
    .data_we(data_we), .data_byte(data_byte),
    .out_o(out_o), .stat_o(stat_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    logic  val;
    string tag;
  } exp_t;

  exp_t sb[$];
  exp_t m_e;
  int   n_chk = 0;
  int   n_err = 0;

  task automatic expect_at(input int at, input logic v, input string tag);
    sb.push_back('{at, v, tag});
  endtask

  task automatic expect_span(input int from, input int len, input logic v, input string tag);
    for (int i = 0; i < len; i++) expect_at(from + i, v, tag);
  endtask

  task automatic expect_square(input int e, input int hi, input int lo, input int periods, input string tag);
    for (int p = 0; p < periods; p++) begin
      expect_span(e + p * (hi + lo), hi, 1'b1, tag);
      expect_span(e + p * (hi + lo) + hi, lo, 1'b0, tag);
    end
  endtask

  // monitor: compares the front of the scoreboard once the outputs have settled
  always @(negedge clk) begin
    #1;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      m_e = sb.pop_front();
      n_chk++;
      if (m_e.at != cyc) begin
        n_err++;
        $display("FAIL %s: sample missed, actual cycle=%0d expected cycle=%0d", m_e.tag, cyc, m_e.at);
      end else if (out_o !== m_e.val) begin
        n_err++;
        $display("FAIL %s: out_o actual=%b expected=%b at cycle %0d", m_e.tag, out_o, m_e.val, cyc);
      end else if (stat_o !== out_o) begin
        n_err++;
        $display("FAIL R10: stat_o actual=%b expected=%b at cycle %0d", stat_o, out_o, cyc);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [7:0] b, output int eff);
    @(negedge clk);
    ctrl_byte = b;
    ctrl_we   = 1'b1;
    @(negedge clk);
    ctrl_we = 1'b0;
    eff     = cyc;
  endtask

  task automatic wr_data(input logic [7:0] b, output int eff);
    @(negedge clk);
    data_byte = b;
    data_we   = 1'b1;
    @(negedge clk);
    data_we = 1'b0;
    eff     = cyc;
  endtask

  initial begin
    int e;
    idle(3);
    rst = 1'b0;
    // R1: reset state, then a data write before any control word
    expect_span(cyc, 3, 1'b0, "R1 reset low");
    idle(3);
    wr_data(8'h02, e);
    expect_span(e, 6, 1'b0, "R1 unconfigured write ignored");
    idle(6);

    // R3/R5: two-byte load of 5 in one-shot mode (ch2, acc 11, mode 000)
    wr_ctrl(8'hB0, e);
    expect_at(e, 1'b0, "R6 one-shot control low");
    wr_data(8'h05, e);
    expect_span(e, 12, 1'b0, "R3 low byte alone starts nothing");
    idle(12);
    wr_data(8'h00, e);
    expect_span(e, 5, 1'b0, "R5 low while counting");
    expect_span(e + 5, 8, 1'b1, "R5 high at terminal count");
    idle(13);

    // R2: ignored control words while the one-shot output is high
    wr_ctrl(8'h30, e);
    expect_span(e, 3, 1'b1, "R2 channel 0 word ignored");
    idle(3);
    wr_ctrl(8'h70, e);
    expect_span(e, 3, 1'b1, "R2 channel 1 word ignored");
    idle(3);
    wr_ctrl(8'hB4, e);
    expect_span(e, 3, 1'b1, "R2 unsupported mode ignored");
    idle(3);
    wr_ctrl(8'h80, e);
    expect_span(e, 3, 1'b1, "R2 access 00 ignored");
    idle(3);

    // R6: own control word forces one-shot output low and stops
    wr_ctrl(8'hB0, e);
    expect_span(e, 10, 1'b0, "R6 control word forces low");
    idle(10);

    // R4: low-byte-only access, count 3 (ch2, acc 01, mode 000)
    wr_ctrl(8'h90, e);
    wr_data(8'h03, e);
    expect_span(e, 3, 1'b0, "R4 single byte count low");
    expect_span(e + 3, 5, 1'b1, "R4 single byte count high");
    idle(8);

    // R8: gate low for 3 cycles delays terminal count by 3; reload restarts (R5)
    wr_data(8'h04, e);
    gate = 1'b0;
    expect_span(e, 7, 1'b0, "R8 gate pause low");
    expect_span(e + 7, 4, 1'b1, "R8 gate pause high");
    idle(3);
    gate = 1'b1;
    idle(9);

    // R8: timebase strobe low for 2 cycles
    wr_ctrl(8'h90, e);
    wr_data(8'h05, e);
    tb_tick = 1'b0;
    expect_span(e, 7, 1'b0, "R8 tick pause low");
    expect_span(e + 7, 3, 1'b1, "R8 tick pause high");
    idle(2);
    tb_tick = 1'b1;
    idle(9);

    // R7: square wave, even count 6 (ch2, acc 11, mode 011)
    wr_ctrl(8'hB6, e);
    expect_at(e, 1'b1, "R6 square control high");
    wr_data(8'h06, e);
    wr_data(8'h00, e);
    expect_square(e, 3, 3, 3, "R7 even square");
    idle(18);

    // R7: odd count 5, mode 111 spelling
    wr_ctrl(8'hBE, e);
    wr_data(8'h05, e);
    wr_data(8'h00, e);
    expect_square(e, 3, 2, 3, "R7 odd square");
    idle(15);

    // R7: count 1
    wr_ctrl(8'hB6, e);
    wr_data(8'h01, e);
    wr_data(8'h00, e);
    expect_square(e, 1, 1, 4, "R7 count one square");
    idle(8);

    // R9: zero count acts as 65536
    wr_ctrl(8'hB0, e);
    wr_data(8'h00, e);
    wr_data(8'h00, e);
    expect_at(e, 1'b0, "R9 zero count start");
    expect_at(e + 65535, 1'b0, "R9 zero count last low");
    expect_at(e + 65536, 1'b1, "R9 zero count terminal");
    idle(65540);

    idle(2);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #600000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule